// File: doc/BRIEF.md
# Protected-register watchdog timer

This block supervises software from a slow 32.768 kHz timebase. A 16-bit counter runs while the watchdog is enabled. A 4-bit prescale field chooses which power-of-two count ends the window, so the timeout ranges from 512 to 65536 timebase periods. When the window expires without a kick, the block raises a one-cycle system reset request or a level interrupt. A control bit picks which of the two it raises. Two prescale codes above the timer range request a reset at once instead of timing anything. One of these two codes also marks the reset as a serial-download reset.

All configuration sits in one 8-bit register on a strobe/write-enable bus, and it reads back continuously. A data write takes effect only when an arming write comes directly before it. A sticky status flag records every expiry. A software-visible system reset restores the configuration but keeps the flag, so boot code can tell a watchdog reset from a hardware reset. A lock input forces the watchdog on and forces the response to reset. This protects both settings from software.

Top module: `wdt_guard`

## Requirements
- R1: After hardware reset the register reads 0x72: prescale 7, enabled, response reset, status 0. The reset request and the interrupt are low. With no bus traffic, a reset request appears 65536 cycles after reset release.
- R2: Register layout: bits [7:4] prescale, bit 3 response (1 = interrupt), bit 2 status, bit 1 enable, bit 0 reads 0. With prescale P in 0..7, the window is 2^(P+9) cycles. On expiry with response 0, wdt_rst is high for exactly one cycle, 2^(P+9) cycles after the edge that cleared the counter. The counter then restarts.
- R3: An arming access is a write with bit 0 set. A register write takes effect only on the bus access immediately after an arming access. Any other access in between cancels the arming, and a lone write is ignored. A data write with bit 0 set stores bit 0 as 0.
- R4: With response 1, expiry raises no reset request. It sets status, and wdt_irq follows status AND response until software clears status.
- R5: Every expiry sets status. A data write with bit 2 = 0 clears it, and a write with bit 2 = 1 leaves it unchanged. If an expiry and a clearing write fall on the same edge, status ends at 1.
- R6: A pulse on sys_rst restores prescale 7, enable 1 and response 0, and keeps status. Only rst_n clears status.
- R7: With enable 0 the counter never expires. A data write with bit 1 = 1 restarts the window from zero.
- R8: A data write that changes the prescale restarts the window from zero under the new prescale.
- R9: Writing prescale 8 or 9 with the watchdog enabled gives one wdt_rst pulse in the cycle after the write edge, whatever the response bit. Code 9 also pulses wdt_dl together with it, and sets status.
- R10: A data write with a prescale of 10 to 15 leaves the prescale unchanged. The other fields in that write are still stored.
- R11: While lock_hold is high, the enable bit reads 1 and the response bit reads 0. Expiry then requests a reset, whatever software wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz timebase |
| rst_n | input | 1 | Hardware reset, active low, asynchronous; clears everything |
| sys_rst | input | 1 | Synchronous system reset; restores configuration, keeps status |
| lock_hold | input | 1 | Forces enable on and response to reset |
| bus_stb | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | Access is a write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read-back |
| wdt_rst | output | 1 | One-cycle system reset request |
| wdt_dl | output | 1 | Marks a reset request as a serial-download reset |
| wdt_irq | output | 1 | Watchdog interrupt level |

## Verification
The collision to provoke is an expiry landing on the same edge as a software write that clears status. The bench times an armed write so its data edge falls on the cycle the window ends. It then requires status and the interrupt to read 1 afterwards, because the set must win. Kicks and prescale changes are also placed partway through a running window. The scoreboard then requires the pulse at the new position and flags any pulse at the old one.

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int CNT_W   = 16,
  parameter int BASE_SH = 9,
  parameter int PRE_RST = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sys_rst,
  input  logic       lock_hold,
  input  logic       bus_stb,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wdt_rst,
  output logic       wdt_dl,
  output logic       wdt_irq
);
  localparam int MAX_TAP = CNT_W - BASE_SH;
  localparam logic [3:0] TAP_TOP = 4'(MAX_TAP);
  localparam logic [3:0] IMM_RST = 4'(MAX_TAP + 1);
  localparam logic [3:0] IMM_DL  = 4'(MAX_TAP + 2);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [3:0]       pre_q;
  logic             resp_q, en_q, wds_q, arm_q, imm_q, imm_dl_q, rst_q, dl_q;
  logic [CNT_W-1:0] cnt_q, lim;

  wire       wr       = bus_stb & bus_we;
  wire       data_wr  = wr & arm_q & ~sys_rst;
  wire       en_eff   = en_q | lock_hold;
  wire       resp_eff = resp_q & ~lock_hold;
  wire [3:0] pre_nx   = (bus_wdata[7:4] <= IMM_DL) ? bus_wdata[7:4] : pre_q;
  wire       en_nx    = bus_wdata[1] | lock_hold;
  wire       is_tap   = pre_q <= TAP_TOP;

  assign lim = ALL_ONES >> (TAP_TOP - pre_q);

  wire hit  = en_eff & is_tap & (cnt_q == lim);
  wire kick = data_wr & (bus_wdata[1] | (pre_nx != pre_q));
  wire fire = (hit & ~resp_eff) | imm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (sys_rst || kick || hit || !en_eff) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= 4'(PRE_RST);
      resp_q <= 1'b0;
      en_q   <= 1'b1;
      arm_q  <= 1'b0;
    end else if (sys_rst) begin
      pre_q  <= 4'(PRE_RST);
      resp_q <= 1'b0;
      en_q   <= 1'b1;
      arm_q  <= 1'b0;
    end else begin
      if (bus_stb) arm_q <= wr & ~arm_q & bus_wdata[0];
      if (data_wr) begin
        pre_q  <= pre_nx;
        resp_q <= bus_wdata[3];
        en_q   <= bus_wdata[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wds_q <= 1'b0;
    end else if (hit || imm_q) begin
      wds_q <= 1'b1;
    end else if (data_wr && !bus_wdata[2]) begin
      wds_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_q    <= 1'b0;
      imm_dl_q <= 1'b0;
      rst_q    <= 1'b0;
      dl_q     <= 1'b0;
    end else begin
      imm_q    <= data_wr & en_nx & (pre_nx >= IMM_RST);
      imm_dl_q <= pre_nx == IMM_DL;
      rst_q    <= fire;
      dl_q     <= imm_q & imm_dl_q;
    end
  end

  assign bus_rdata = {pre_q, resp_eff, wds_q, en_eff, 1'b0};
  assign wdt_rst   = rst_q;
  assign wdt_dl    = dl_q;
  assign wdt_irq   = wds_q & resp_eff;
endmodule

module wdt_guard_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       sys_rst,
  input logic       lock_hold,
  input logic       bus_stb,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       wdt_rst,
  input logic       wdt_dl,
  input logic       wdt_irq
);
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  assert_pulse_sets_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> bus_rdata[2]);
  assert_irq_needs_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_irq |-> bus_rdata[2]);
  assert_dl_with_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_dl |-> wdt_rst);
  assert_status_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && bus_rdata[2]) |=> bus_rdata[2]);
  assert_lock_forces_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lock_hold |-> (bus_rdata[1] && !bus_rdata[3]));
  assert_bad_code_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_stb && bus_we && bus_wdata[7:4] > 4'd9 && !sys_rst) |=> $stable(bus_rdata[7:4]));
endmodule

bind wdt_guard wdt_guard_sva u_wdt_guard_sva (.*);

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, sys_rst = 0, lock_hold = 0;
  logic bus_stb = 0, bus_we = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic wdt_rst, wdt_dl, wdt_irq;

  int compared = 0, mismatched = 0, cyc = 0;
  typedef struct { int at; bit dl; } exp_t;
  exp_t exq[$];

  wdt_guard u_wdt_guard (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (exq.size() > 0 && exq[0].at == cyc) begin
        compared++;
        if (!wdt_rst || wdt_dl != exq[0].dl) begin
          mismatched++;
          $display("FAIL R2/R9 pulse at cycle %0d: rst=%0b dl=%0b expected rst=1 dl=%0b",
                   cyc, wdt_rst, wdt_dl, exq[0].dl);
        end
        void'(exq.pop_front());
      end else if (wdt_rst) begin
        compared++; mismatched++;
        $display("FAIL R2/R7 unexpected reset pulse at cycle %0d: rst=1 expected 0", cyc);
      end
    end
  end

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic acc(bit we, logic [7:0] d);
    bus_stb = 1; bus_we = we; bus_wdata = d;
    @(negedge clk);
    bus_stb = 0; bus_we = 0;
  endtask

  task automatic put(logic [7:0] d);
    acc(1, 8'h01);
    acc(1, d);
  endtask

  task automatic expect_rst(int at, bit dl);
    exp_t e;
    e.at = at; e.dl = dl;
    exq.push_back(e);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    int e, l;
    tick(3);
    rst_n = 1;
    chk("R1 reset value", bus_rdata, 8'h72);
    chk("R1 outputs low", {6'd0, wdt_rst, wdt_irq}, 8'h00);
    expect_rst(cyc + 65536, 0);
    tick(65540);
    chk("R5 status after timeout", bus_rdata, 8'h76);
    put(8'h00);
    chk("R5 R7 cleared and disabled", bus_rdata, 8'h00);

    acc(1, 8'h02);
    chk("R3 lone write ignored", bus_rdata, 8'h00);
    acc(1, 8'h01); acc(0, 8'h00); acc(1, 8'h12);
    chk("R3 read cancels arming", bus_rdata, 8'h00);
    put(8'h13);
    chk("R3 armed write stored, bit0 reads 0", bus_rdata, 8'h12);
    tick(300);
    put(8'h12);
    expect_rst(cyc + 1024, 0);
    tick(1030);
    chk("R2 R7 kicked window expired", bus_rdata, 8'h16);

    put(8'h16);
    chk("R5 writing 1 keeps status", bus_rdata, 8'h16);
    put(8'h02);
    chk("R5 R8 prescale change stored", bus_rdata, 8'h02);
    tick(200);
    put(8'h12);
    expect_rst(cyc + 1024, 0);
    tick(1030);
    put(8'h00);
    tick(2000);
    chk("R7 disabled never expires", bus_rdata, 8'h00);

    put(8'h0A);
    e = cyc;
    tick(511);
    chk("R4 no interrupt before window", {7'd0, wdt_irq}, 8'h00);
    tick(1);
    chk("R4 interrupt at expiry", {6'd0, wdt_irq, wdt_rst}, 8'h02);
    tick(600);
    chk("R4 interrupt held", {7'd0, wdt_irq}, 8'h01);
    put(8'h08);
    chk("R4 interrupt drops on clear", {7'd0, wdt_irq}, 8'h00);

    put(8'h0A);
    e = cyc;
    tick(510);
    put(8'h0A);
    chk("R5 set wins over same-edge clear", {6'd0, bus_rdata[2], wdt_irq}, 8'h03);
    put(8'h00);

    put(8'h82);
    expect_rst(cyc + 1, 0);
    tick(3);
    put(8'h00);
    put(8'h9A);
    expect_rst(cyc + 1, 1);
    tick(3);
    put(8'h00);
    chk("R9 cleared after immediate codes", bus_rdata, 8'h00);

    put(8'h30);
    chk("R10 valid prescale stored", bus_rdata, 8'h30);
    put(8'hF8);
    chk("R10 invalid prescale kept", bus_rdata, 8'h38);
    put(8'h00);

    put(8'h82);
    expect_rst(cyc + 1, 0);
    tick(3);
    chk("R9 status after immediate reset", bus_rdata, 8'h86);
    sys_rst = 1; tick(1); sys_rst = 0;
    chk("R6 system reset keeps status", bus_rdata, 8'h76);
    put(8'h00);
    put(8'h82);
    expect_rst(cyc + 1, 0);
    tick(3);
    rst_n = 0; tick(2); rst_n = 1;
    chk("R6 hardware reset clears status", bus_rdata, 8'h72);
    put(8'h00);

    lock_hold = 1;
    l = cyc;
    expect_rst(l + 512, 0);
    tick(1);
    chk("R11 lock forces enable", bus_rdata, 8'h02);
    put(8'h08);
    chk("R11 lock overrides written fields", bus_rdata, 8'h02);
    tick(l + 515 - cyc);
    chk("R11 locked expiry resets, no irq", {6'd0, bus_rdata[2], wdt_irq}, 8'h02);
    lock_hold = 0;
    put(8'h00);
    tick(5);
    compared++;
    if (exq.size() != 0) begin
      mismatched++;
      $display("FAIL R2 pending pulses: got %0d expected 0", exq.size());
    end
    summary();
  end
endmodule